// File: doc/BRIEF.md
# Fractional Horizontal Pixel Decimator

This block thins out the pixels of an incoming active-video line so that an inset picture can be stored at a reduced width. A 6-bit reduction setting N selects the scale N/96. Each valid input pixel adds N to a phase accumulator. When the sum reaches the modulus of 96, the pixel is kept and the accumulator wraps. A kept pixel leaves the block unchanged with a write-enable strobe, ready for an inset store.

N is meaningful from 1 to 48, so the output is at most half as wide as the input. A setting of zero switches the inset off and nothing is emitted. A start-of-line strobe clears the phase and the per-line output counter. Every line therefore produces the same kept-pixel pattern, and the counter tells the store how many pixels the current line has delivered so far.

Top module: `hdec_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_en_o` is 0 and `kept_count_o` is 0.
- R2: When `reduce_i` is 0, no pixel is kept: `wr_en_o` stays 0 and `kept_count_o` does not increase.
- R3: Any `reduce_i` value above 48 behaves exactly as 48, so two consecutive cycles never both show `wr_en_o` high.
- R4: With N = 48, the 2nd, 4th, 6th and every further even-numbered valid pixel of a line is kept.
- R5: On each valid pixel the phase P becomes P+N. If P+N >= 96 the pixel is kept and P becomes P+N-96. The phase is always below 96.
- R6: `line_start_i` clears the phase and `kept_count_o` in the same clock. A valid pixel that arrives in that cycle is the first pixel of the new line.
- R7: After a line of L valid pixels, `kept_count_o` equals floor(L*N/96) for the clamped N.
- R8: A kept pixel appears on `pix_o` with `wr_en_o` high exactly one clock after it was presented on `pix_i`.
- R9: A cycle with `pix_valid_i` low produces no output in the next cycle and leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Start-of-line strobe, clears phase and counter |
| pix_valid_i | input | 1 | Input pixel is valid this cycle |
| pix_i | input | PIX_W | Input pixel value |
| reduce_i | input | 6 | Reduction setting N (scale N/96; 0 = off) |
| wr_en_o | output | 1 | Kept-pixel strobe |
| pix_o | output | PIX_W | Kept pixel value |
| kept_count_o | output | CNT_W | Pixels kept since line start |

## Verification
The assertions assume that a line has no more than MAX_LINE valid pixels, so the counter cannot wrap. They also assume that `reduce_i` stays steady inside a line, because the keep pattern is only defined for one ratio per line. The stimulus changes the setting only on cycles where `line_start_i` is high. It uses lines of 720 pixels or fewer, with random gaps in the valid strobe, and restarts a line partway through to exercise the clear. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/hdec_pkg.sv
package hdec_pkg;
    localparam int RATIO_W   = 6;
    localparam int RATIO_MAX = 48;
    localparam int PHASE_MOD = 96;
    localparam int PHASE_W   = $clog2(PHASE_MOD + RATIO_MAX);

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic   keep;
        phase_t next_phase;
    } phase_step_t;

    function automatic ratio_t clamp_ratio(input ratio_t r);
        return (r > ratio_t'(RATIO_MAX)) ? ratio_t'(RATIO_MAX) : r;
    endfunction

    function automatic phase_step_t advance(input phase_t p, input ratio_t n);
        phase_step_t s;
        phase_t sum;
        sum = p + phase_t'(n);
        s.keep = (sum >= phase_t'(PHASE_MOD));
        s.next_phase = s.keep ? (sum - phase_t'(PHASE_MOD)) : sum;
        return s;
    endfunction
endpackage

// File: rtl/hdec_ratio_clamp.sv
module hdec_ratio_clamp
    import hdec_pkg::*;
(
    input  ratio_t raw_i,
    output ratio_t ratio_o,
    output logic   active_o
);
    always_comb begin
        ratio_o  = clamp_ratio(raw_i);
        active_o = (ratio_o != '0);
    end
endmodule

// File: rtl/hdec_phase_accum.sv
module hdec_phase_accum
    import hdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   line_start_i,
    input  logic   valid_i,
    input  logic   active_i,
    input  ratio_t ratio_i,
    output logic   keep_o
);
    phase_t      phase_q;
    phase_t      base;
    phase_step_t step;

    always_comb begin
        base   = line_start_i ? '0 : phase_q;
        step   = advance(base, ratio_i);
        keep_o = valid_i && active_i && step.keep;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (valid_i && active_i) begin
            phase_q <= step.next_phase;
        end else if (line_start_i) begin
            phase_q <= '0;
        end
    end

    a_r5_phase_below_modulus: assert property (@(posedge clk) disable iff (rst)
        phase_q < phase_t'(PHASE_MOD));

    a_r9_phase_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(valid_i) && !$past(line_start_i) && !$past(rst)) |-> $stable(phase_q));
endmodule

// File: rtl/hdec_out_stage.sv
module hdec_out_stage #(
    parameter int PIX_W = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start_i,
    input  logic             keep_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             wr_en_o,
    output logic [PIX_W-1:0] pix_o,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o <= 1'b0;
            pix_o   <= '0;
            count_o <= '0;
        end else begin
            wr_en_o <= keep_i;
            if (keep_i) begin
                pix_o <= pix_i;
            end
            if (line_start_i) begin
                count_o <= keep_i ? CNT_W'(1) : '0;
            end else if (keep_i) begin
                count_o <= count_o + CNT_W'(1);
            end
        end
    end

    a_r8_data_follows_input: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> pix_o == $past(pix_i));

    a_r7_count_steps_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !$past(line_start_i)) |-> count_o == $past(count_o) + CNT_W'(1));

    a_r6_count_cleared: assert property (@(posedge clk) disable iff (rst)
        ($past(line_start_i) && !wr_en_o) |-> count_o == '0);
endmodule

// File: rtl/hdec_top.sv
module hdec_top
    import hdec_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int MAX_LINE = 4096,
    localparam int CNT_W   = $clog2(MAX_LINE / 2 + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [5:0]       reduce_i,
    output logic             wr_en_o,
    output logic [PIX_W-1:0] pix_o,
    output logic [CNT_W-1:0] kept_count_o
);
    ratio_t ratio;
    logic   active;
    logic   keep;

    hdec_ratio_clamp u_clamp (
        .raw_i   (reduce_i),
        .ratio_o (ratio),
        .active_o(active)
    );

    hdec_phase_accum u_phase (
        .clk         (clk),
        .rst         (rst),
        .line_start_i(line_start_i),
        .valid_i     (pix_valid_i),
        .active_i    (active),
        .ratio_i     (ratio),
        .keep_o      (keep)
    );

    hdec_out_stage #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .line_start_i(line_start_i),
        .keep_i      (keep),
        .pix_i       (pix_i),
        .wr_en_o     (wr_en_o),
        .pix_o       (pix_o),
        .count_o     (kept_count_o)
    );

    a_r2_off_is_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(reduce_i) == 6'd0) |-> !wr_en_o);

    a_r3_never_adjacent: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && $past(wr_en_o)));

    a_r9_idle_no_output: assert property (@(posedge clk) disable iff (rst)
        !$past(pix_valid_i) |-> !wr_en_o);

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en_o && kept_count_o == '0));
endmodule

// File: tb/test_hdec_top.sv
module test_hdec_top;
    localparam int PIX_W = 10;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_start_i = 1'b0;
    logic             pix_valid_i = 1'b0;
    logic [PIX_W-1:0] pix_i = '0;
    logic [5:0]       reduce_i = '0;
    logic             wr_en_o;
    logic [PIX_W-1:0] pix_o;
    logic [CNT_W-1:0] kept_count_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    int m_phase = 0;
    int m_cnt = 0;
    bit e_valid = 0;
    int e_pix = 0;

    always #4 clk = ~clk;

    hdec_top i_hdec_top (
        .clk(clk), .rst(rst), .line_start_i(line_start_i),
        .pix_valid_i(pix_valid_i), .pix_i(pix_i), .reduce_i(reduce_i),
        .wr_en_o(wr_en_o), .pix_o(pix_o), .kept_count_o(kept_count_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: compare model vs DUT, then drive and advance model
    task automatic step(input bit ls, input bit v, input int d, input int n, input string req);
        int nc;
        @(negedge clk);
        check(wr_en_o == e_valid, {req, " wr_en"}, int'(wr_en_o), int'(e_valid));
        if (e_valid) check(int'(pix_o) == e_pix, {req, " R8 data"}, int'(pix_o), e_pix);
        check(int'(kept_count_o) == m_cnt, {req, " count"}, int'(kept_count_o), m_cnt);
        line_start_i = ls; pix_valid_i = v; pix_i = PIX_W'(d); reduce_i = 6'(n);
        nc = (n > 48) ? 48 : n;
        if (ls) begin m_phase = 0; m_cnt = 0; end
        e_valid = 0;
        if (v && nc > 0) begin
            m_phase += nc;
            if (m_phase >= 96) begin
                m_phase -= 96; e_valid = 1; e_pix = d; m_cnt++;
            end
        end
    endtask

    task automatic run_line(input int n, input int len, input bit gaps, input string req);
        int sent = 0;
        int nc = (n > 48) ? 48 : n;
        while (sent < len) begin
            bit v = (!gaps || sent == 0) ? 1'b1 : 1'($urandom_range(0, 3) != 0);
            step(sent == 0, v, (sent * 7 + 3) % 1024, n, req);
            if (v) sent++;
        end
        step(0, 0, 0, n, req);
        check(int'(kept_count_o) == (len * nc) / 96, "R7 line total",
              int'(kept_count_o), (len * nc) / 96);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wr_en_o == 0 && kept_count_o == 0, "R1 reset", int'(kept_count_o), 0);
        rst = 0;
        step(0, 0, 0, 0, "R1");
        // R4: N=48 keeps 2nd, 4th ... pixel
        step(1, 1, 11, 48, "R4");
        step(0, 1, 22, 48, "R4");
        step(0, 1, 33, 48, "R4");
        check(wr_en_o == 1 && pix_o == 22, "R4 second pixel kept", int'(pix_o), 22);
        step(0, 1, 44, 48, "R4");
        check(wr_en_o == 0, "R4 third pixel dropped", int'(wr_en_o), 0);
        run_line(48, 720, 0, "R4");
        run_line(1, 720, 0, "R5");
        run_line(7, 500, 1, "R5");
        run_line(33, 720, 1, "R9");
        run_line(0, 300, 0, "R2");
        run_line(63, 400, 0, "R3");
        run_line(25, 720, 0, "R6");
        run_line(25, 720, 0, "R6");
        // R6: restart mid-line
        for (int i = 0; i < 37; i++) step(i == 0, 1, i, 40, "R6");
        run_line(40, 200, 1, "R6");
        check(1'b1, "R6 restart", 0, 0);
        run_line(17, 96, 0, "R7");
        step(0, 0, 0, 17, "R9");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule